// File: doc/BRIEF.md
# Load/Store Byte-Lane Steering Unit

This unit sits between the load/store path of a processor and a 32-bit, byte-addressed data memory. On the load side it takes the byte offset of an access within its memory word, the access size, a signed/unsigned flag and the raw word read from memory. It picks out the addressed bytes and returns them right-justified, either sign-extended or zero-filled to 32 bits. On the store side it moves the store value into the byte lanes that the access covers and raises one write enable per lane.

A compile-time parameter chooses how byte addresses map onto lanes. With the little-endian option, the lowest byte address of a word is lane 0 (bits 7:0). With the big-endian option, the lowest byte address is lane 3 (bits 31:24). Every access must be naturally aligned. Any access that breaks this rule, and any use of the reserved size code, raises a misalignment flag. While that flag is high, all write enables are held low and the load result is zero.

The steering logic is purely combinational. A second parameter can add one register stage on all outputs; that stage resets to zero.

Top module: `bytelane_unit`

## Requirements
- R1: A byte load (size code 00) returns the byte at offset a. In little-endian mode that byte is in lane a, bits 8a+7:8a. In big-endian mode it is in lane 3-a. For example, raw word 0x114488FF at offset 0 gives byte 0xFF in little-endian mode and byte 0x11 in big-endian mode.
- R2: A half-word load (size code 01) returns the two bytes at offsets a and a+1. In big-endian mode the byte at offset a is the upper byte of the result. In little-endian mode it is the lower byte. A word load (size code 10) returns the raw word unchanged.
- R3: When the signed flag is 1, a byte result is sign-extended from its bit 7 and a half-word result from its bit 15. For example, byte 0xFF loads as 0xFFFFFFFF and byte 0x11 loads as 0x00000011.
- R4: When the signed flag is 0, every result bit above the access size is zero. For example, byte 0xFF loads as 0x000000FF.
- R5: Alignment rules:
  - A word access is legal only at offset 0.
  - A half-word access is legal only at an even offset.
  - A byte access is legal at any offset.
  - Size code 11 is always illegal.
  
  An illegal access sets the misalignment output to 1.
- R6: While the misalignment output is 1, all four write enables are 0 and the load data is 0.
- R7: The write enables are nonzero only when the store strobe is 1 and the access is legal. A byte store enables one lane, a half-word store enables two adjacent lanes, and a word store enables all four. The lanes are the ones that R1 and R2 assign to the addressed bytes.
- R8: On every enabled lane, the store data carries the store value's bytes in the memory order of R2. The byte at offset a gets the value's upper byte in big-endian mode and its lowest byte in little-endian mode.
- R9: With the output register enabled (the default), every output shows the result for the inputs present at the previous rising clock edge. While reset is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| addr_off_i | input | 2 | Byte offset of the access within its memory word |
| size_i | input | 2 | Access size: 00 byte, 01 half-word, 10 word, 11 reserved |
| sext_i | input | 1 | 1 = sign-extend the load result, 0 = zero-fill |
| store_i | input | 1 | Store strobe that allows the write enables |
| ld_raw_i | input | 32 | Raw word read from data memory |
| st_val_i | input | 32 | Right-justified value to be stored |
| ld_data_o | output | 32 | Extended load result |
| st_data_o | output | 32 | Store value steered into its byte lanes |
| st_be_o | output | 4 | Per-lane write enables, bit k for bits 8k+7:8k |
| misalign_o | output | 1 | Access breaks the natural-alignment rule |

## Verification
On every clock, the assertions check the signals between the alignment checker, the load extractor and the store packer. They cover the alignment rules, the extension of byte results, how many lanes a store enables, and that a faulting access produces no enables and no load data. Only the bench's scenarios can show the rest, by comparing against a byte-array model of memory for both endian settings. That covers which lane each offset reaches, the byte order inside half-words, where the store bytes land, and the one-cycle latency of the output register.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'b00,
      ACC_HALF = 2'b01,
      ACC_WORD = 2'b10,
      ACC_RSVD = 2'b11
   } acc_size_e;

   localparam int unsigned WORD_BITS = 32;
   localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/bl_align_chk.sv
module bl_align_chk
   import bytelane_pkg::*;
#(
   parameter int unsigned LIDX_W = 2
) (
   input  logic [LIDX_W-1:0] off_i,
   input  acc_size_e         size_i,
   output logic              misalign_o
);

   initial begin
      if (LIDX_W != 2) $error("bl_align_chk: LIDX_W must be 2");
   end

   always_comb begin
      unique case (size_i)
         ACC_BYTE: misalign_o = 1'b0;
         ACC_HALF: misalign_o = off_i[0];
         ACC_WORD: misalign_o = |off_i;
         default:  misalign_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/bl_lane_map.sv
module bl_lane_map
   import bytelane_pkg::*;
#(
   parameter int unsigned LANES      = 4,
   parameter int unsigned LIDX_W     = 2,
   parameter bit          BIG_ENDIAN = 1'b0
) (
   input  logic [LIDX_W-1:0] off_i,
   input  acc_size_e         size_i,
   output logic [LIDX_W-1:0] lane_o
);

   localparam logic [LIDX_W:0] LANE_CNT = (LIDX_W+1)'(LANES);

   logic [LIDX_W:0] nbytes;

   always_comb begin
      unique case (size_i)
         ACC_BYTE: nbytes = (LIDX_W+1)'(1);
         ACC_HALF: nbytes = (LIDX_W+1)'(2);
         default:  nbytes = LANE_CNT;
      endcase
   end

   generate
      if (BIG_ENDIAN) begin : g_big
         logic [LIDX_W:0] first_lane;
         assign first_lane = LANE_CNT - nbytes - {1'b0, off_i};
         assign lane_o     = first_lane[LIDX_W-1:0];
         logic unused_top;
         assign unused_top = first_lane[LIDX_W];
      end else begin : g_little
         logic unused_n;
         assign unused_n = ^nbytes;
         assign lane_o   = off_i;
      end
   endgenerate

endmodule

// File: rtl/bl_load_extract.sv
module bl_load_extract
   import bytelane_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LIDX_W = 2
) (
   input  logic [WORD_W-1:0] raw_i,
   input  logic [LIDX_W-1:0] lane_i,
   input  acc_size_e         size_i,
   input  logic              sext_i,
   input  logic              kill_i,
   output logic [WORD_W-1:0] data_o
);

   localparam int unsigned SH_W = LIDX_W + 3;

   logic [SH_W-1:0]   shamt;
   logic [WORD_W-1:0] aligned;

   assign shamt   = {lane_i, 3'b000};
   assign aligned = raw_i >> shamt;

   always_comb begin
      data_o = '0;
      if (!kill_i) begin
         unique case (size_i)
            ACC_BYTE: data_o = {{(WORD_W-8){sext_i & aligned[7]}}, aligned[7:0]};
            ACC_HALF: data_o = {{(WORD_W-16){sext_i & aligned[15]}}, aligned[15:0]};
            default:  data_o = aligned;
         endcase
      end
   end

endmodule

// File: rtl/bl_store_pack.sv
module bl_store_pack
   import bytelane_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LIDX_W = 2
) (
   input  logic [WORD_W-1:0] val_i,
   input  logic [LIDX_W-1:0] lane_i,
   input  acc_size_e         size_i,
   input  logic              store_i,
   input  logic              kill_i,
   output logic [LANES-1:0]  be_o,
   output logic [WORD_W-1:0] data_o
);

   localparam int unsigned SH_W = LIDX_W + 3;

   logic [LANES-1:0] span;
   logic [SH_W-1:0]  shamt;

   assign shamt = {lane_i, 3'b000};

   always_comb begin
      unique case (size_i)
         ACC_BYTE: span = LANES'(4'b0001);
         ACC_HALF: span = LANES'(4'b0011);
         default:  span = '1;
      endcase
   end

   assign be_o   = (store_i && !kill_i) ? (span << lane_i) : '0;
   assign data_o = val_i << shamt;

endmodule

// File: rtl/bytelane_unit.sv
module bytelane_unit
   import bytelane_pkg::*;
#(
   parameter int unsigned WORD_W     = WORD_BITS,
   parameter bit          BIG_ENDIAN = 1'b0,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_off_i,
   input  logic [1:0]        size_i,
   input  logic              sext_i,
   input  logic              store_i,
   input  logic [WORD_W-1:0] ld_raw_i,
   input  logic [WORD_W-1:0] st_val_i,
   output logic [WORD_W-1:0] ld_data_o,
   output logic [WORD_W-1:0] st_data_o,
   output logic [3:0]        st_be_o,
   output logic              misalign_o
);

   localparam int unsigned LANES  = WORD_W / LANE_BITS;
   localparam int unsigned LIDX_W = $clog2(LANES);

   initial begin
      if (WORD_W != 32) $error("bytelane_unit: WORD_W must be 32");
      if (LANES * LANE_BITS != WORD_W) $error("bytelane_unit: WORD_W not a lane multiple");
   end

   acc_size_e         size_e;
   logic [LIDX_W-1:0] lane;
   logic              mis_c;
   logic [WORD_W-1:0] ld_c;
   logic [WORD_W-1:0] sd_c;
   logic [LANES-1:0]  be_c;

   assign size_e = acc_size_e'(size_i);

   bl_align_chk #(.LIDX_W(LIDX_W)) align_i (
      .off_i      (addr_off_i),
      .size_i     (size_e),
      .misalign_o (mis_c)
   );

   bl_lane_map #(.LANES(LANES), .LIDX_W(LIDX_W), .BIG_ENDIAN(BIG_ENDIAN)) map_i (
      .off_i  (addr_off_i),
      .size_i (size_e),
      .lane_o (lane)
   );

   bl_load_extract #(.WORD_W(WORD_W), .LIDX_W(LIDX_W)) ld_i (
      .raw_i  (ld_raw_i),
      .lane_i (lane),
      .size_i (size_e),
      .sext_i (sext_i),
      .kill_i (mis_c),
      .data_o (ld_c)
   );

   bl_store_pack #(.WORD_W(WORD_W), .LANES(LANES), .LIDX_W(LIDX_W)) st_i (
      .val_i   (st_val_i),
      .lane_i  (lane),
      .size_i  (size_e),
      .store_i (store_i),
      .kill_i  (mis_c),
      .be_o    (be_c),
      .data_o  (sd_c)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ld_data_o  <= '0;
               st_data_o  <= '0;
               st_be_o    <= '0;
               misalign_o <= 1'b0;
            end else begin
               ld_data_o  <= ld_c;
               st_data_o  <= sd_c;
               st_be_o    <= be_c;
               misalign_o <= mis_c;
            end
         end
      end else begin : g_comb
         assign ld_data_o  = ld_c;
         assign st_data_o  = sd_c;
         assign st_be_o    = be_c;
         assign misalign_o = mis_c;
      end
   endgenerate

   // Checks on the signals passed between the sub-blocks
   assert_word_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'b10 && addr_off_i != 2'b00) |-> mis_c);

   assert_half_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'b01 && addr_off_i[0]) |-> mis_c);

   assert_misalign_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mis_c |-> (be_c == '0 && ld_c == '0));

   assert_byte_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'b00 && !sext_i) |-> (ld_c[WORD_W-1:8] == '0));

   assert_byte_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'b00 && sext_i) |-> (ld_c[WORD_W-1:8] == {(WORD_W-8){ld_c[7]}}));

   assert_store_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (store_i && !mis_c) |->
         ($countones(be_c) == ((size_i == 2'b00) ? 1 : (size_i == 2'b01) ? 2 : 4)));

   assert_no_store_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !store_i |-> (be_c == '0));

endmodule

// File: tb/bytelane_unit_tb_top.sv
`timescale 1ns/1ps
module bytelane_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr_off = '0;
   logic [1:0]  size = '0;
   logic        sext = 1'b0;
   logic        store = 1'b0;
   logic [31:0] raw = '0;
   logic [31:0] sval = '0;

   logic [31:0] ld_le, sd_le, ld_be, sd_be;
   logic [3:0]  be_le, be_be;
   logic        mis_le, mis_be;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   bytelane_unit #(.BIG_ENDIAN(1'b0), .OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_off_i(addr_off), .size_i(size),
      .sext_i(sext), .store_i(store), .ld_raw_i(raw), .st_val_i(sval),
      .ld_data_o(ld_le), .st_data_o(sd_le), .st_be_o(be_le), .misalign_o(mis_le));

   bytelane_unit #(.BIG_ENDIAN(1'b1), .OUT_REG(1'b1)) dut_be_i (
      .clk(clk), .rst_n(rst_n), .addr_off_i(addr_off), .size_i(size),
      .sext_i(sext), .store_i(store), .ld_raw_i(raw), .st_val_i(sval),
      .ld_data_o(ld_be), .st_data_o(sd_be), .st_be_o(be_be), .misalign_o(mis_be));

   typedef struct {
      logic [31:0] ld [2];
      logic [3:0]  be [2];
      logic [31:0] sd [2];
      logic        mis;
      string       tag;
   } exp_t;

   exp_t q[$];

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic int nbytes_of(int sz);
      return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
   endfunction

   function automatic bit illegal(int a, int sz);
      return (sz == 3) || ((a % nbytes_of(sz)) != 0);
   endfunction

   // Memory byte at address idx, as the requirements lay it out
   function automatic logic [7:0] mem_byte(bit big, logic [31:0] w, int idx);
      return big ? w[8*(3-idx) +: 8] : w[8*idx +: 8];
   endfunction

   function automatic logic [31:0] model_load(bit big, logic [31:0] w, int a, int sz, bit sx);
      int n = nbytes_of(sz);
      logic [31:0] v = '0;
      if (illegal(a, sz)) return '0;
      for (int j = 0; j < n; j++) begin
         if (big) v = (v << 8) | 32'(mem_byte(big, w, a + j));
         else     v = v | (32'(mem_byte(big, w, a + j)) << (8 * j));
      end
      if (sx && n < 4 && v[8*n-1]) v = v | ~((32'd1 << (8 * n)) - 32'd1);
      return v;
   endfunction

   task automatic model_store(bit big, logic [31:0] d, int a, int sz, bit st,
                              output logic [3:0] be, output logic [31:0] sd);
      int n = nbytes_of(sz);
      be = '0;
      sd = '0;
      if (!st || illegal(a, sz)) return;
      for (int j = 0; j < n; j++) begin
         int lane = big ? 3 - (a + j) : a + j;
         be[lane] = 1'b1;
         sd[8*lane +: 8] = big ? d[8*(n-1-j) +: 8] : d[8*j +: 8];
      end
   endtask

   task automatic drive(int a, int sz, bit sx, bit st, logic [31:0] w, logic [31:0] d, string tag);
      exp_t e;
      @(negedge clk);
      addr_off = a[1:0];
      size     = sz[1:0];
      sext     = sx;
      store    = st;
      raw      = w;
      sval     = d;
      for (int k = 0; k < 2; k++) begin
         e.ld[k] = model_load(k == 1, w, a, sz, sx);
         model_store(k == 1, d, a, sz, st, e.be[k], e.sd[k]);
      end
      e.mis = illegal(a, sz);
      e.tag = $sformatf("%s a=%0d sz=%0d sx=%0d st=%0d", tag, a, sz, sx, st);
      q.push_back(e);
   endtask

   // Monitor: compares one cycle after the inputs were applied
   always @(posedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         #2;
         check({e.tag, " LE ld"}, ld_le, e.ld[0]);
         check({e.tag, " BE ld"}, ld_be, e.ld[1]);
         check({e.tag, " LE be R7"}, 32'(be_le), 32'(e.be[0]));
         check({e.tag, " BE be R7"}, 32'(be_be), 32'(e.be[1]));
         check({e.tag, " LE mis R5"}, 32'(mis_le), 32'(e.mis));
         check({e.tag, " BE mis R5"}, 32'(mis_be), 32'(e.mis));
         if (e.be[0] != 0)
            check({e.tag, " LE sd R8"}, sd_le & {{8{be_le[3]}}, {8{be_le[2]}}, {8{be_le[1]}}, {8{be_le[0]}}}, e.sd[0]);
         if (e.be[1] != 0)
            check({e.tag, " BE sd R8"}, sd_be & {{8{be_be[3]}}, {8{be_be[2]}}, {8{be_be[1]}}, {8{be_be[0]}}}, e.sd[1]);
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R9: reset state
      repeat (2) @(negedge clk);
      check("R9 reset LE ld", ld_le, '0);
      check("R9 reset BE ld", ld_be, '0);
      check("R9 reset be", 32'({be_le, be_be}), '0);
      check("R9 reset mis", 32'({mis_le, mis_be}), '0);
      rst_n = 1'b1;

      // R1 R3 R4: byte loads on every offset, signed and unsigned
      for (int a = 0; a < 4; a++) begin
         drive(a, 0, 1'b1, 1'b0, 32'h114488FF, '0, "R1 R3 byte");
         drive(a, 0, 1'b0, 1'b0, 32'h114488FF, '0, "R1 R4 byte");
         drive(a, 0, 1'b1, 1'b0, 32'h807F0180, '0, "R1 R3 byte");
      end
      // R2 R3 R4: half-word and word loads
      for (int a = 0; a < 4; a += 2) begin
         drive(a, 1, 1'b1, 1'b0, 32'h114488FF, '0, "R2 R3 half");
         drive(a, 1, 1'b0, 1'b0, 32'h114488FF, '0, "R2 R4 half");
         drive(a, 1, 1'b1, 1'b0, 32'h7FFF8000, '0, "R2 R3 half");
      end
      drive(0, 2, 1'b1, 1'b0, 32'h114488FF, '0, "R2 word");
      // R5 R6: illegal accesses, with stores attempted
      drive(1, 1, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hDEADBEEF, "R5 R6 half odd");
      drive(3, 1, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hDEADBEEF, "R5 R6 half odd");
      for (int a = 1; a < 4; a++)
         drive(a, 2, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hDEADBEEF, "R5 R6 word");
      drive(0, 3, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hDEADBEEF, "R5 R6 rsvd");
      // R7 R8: stores of each size at each legal offset
      for (int a = 0; a < 4; a++)
         drive(a, 0, 1'b0, 1'b1, '0, 32'hA1B2C3D4, "R7 R8 byte st");
      for (int a = 0; a < 4; a += 2)
         drive(a, 1, 1'b0, 1'b1, '0, 32'hA1B2C3D4, "R7 R8 half st");
      drive(0, 2, 1'b0, 1'b1, '0, 32'hA1B2C3D4, "R7 R8 word st");
      drive(2, 1, 1'b0, 1'b0, '0, 32'hA1B2C3D4, "R7 no strobe");
      repeat (3) @(negedge clk);

      // R9: output holds until the next rising edge
      addr_off = 2'd0; size = 2'd0; sext = 1'b0; store = 1'b0; raw = 32'h000000AA;
      #1;
      check("R9 hold before edge", ld_le, 32'h0000_0000);
      @(posedge clk); #2;
      check("R9 update after edge", ld_le, 32'h0000_00AA);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule